// File: doc/BRIEF.md
# AXI Transaction and Bandwidth Throttle

This block sits on the read-address and write-address handshakes of one AXI master port. It holds back both the forwarded valid and the returned ready of an address handshake whenever one of its limits would be broken. The address payload itself travels around the block, and only the handshake pair passes through it. There are two kinds of limits. The first caps how many reads and how many writes may be in flight at once. A read is retired by its last R beat, and a write is retired by its B response. The second works inside a repeating clock window. In each window it caps the number of read and write transactions and the number of read and write bytes. Each burst is charged (LEN+1) << SIZE bytes.

Every limit has its own enable. A global pass-through bit overrides all of them. That bit is set by reset, so the port is untouched until software programs the limits and clears it. The limits sit in a small word-addressed register file with one write port and a read-back port. Read-back data is registered and appears one cycle after the address.

Top module: `axi_rate_gate`

## Requirements
- R1: The pass-through bit (word 0, bit 0) resets to 1. While it is set, m_arvalid equals s_arvalid, s_arready equals m_arready, and the same holds for the AW pair, whatever the limits are.
- R2: Register words reset as follows: 0 control = 0x1; 1 in-flight limits = 0; 2 window length = 1024; 3 and 4 read/write count limits = 0x4000; 5 and 7 read/write byte budget low = 0x4000; 6 and 8 byte budget high (4 bits) = 0. reg_rdata returns the word at reg_addr one cycle later.
- R3: With control bit 1 set, a new read is withheld while the reads in flight reach the 7-bit limit in word 1 bits [6:0]. A programmed 0 means 128.
- R4: With control bit 2 set, a new write is withheld while the writes in flight reach the 5-bit limit in word 1 bits [12:8]. A programmed 0 means 32.
- R5: The in-flight read count rises on each AR handshake and falls on RVALID&RREADY&RLAST. The write count rises on each AW handshake and falls on BVALID&BREADY. When both happen in one cycle, the count stays the same.
- R6: A window lasts the 27-bit length in word 2 in cycles (0 acts as 1). In the window's last cycle the per-window counts restart, and a handshake in that cycle is charged to the new window.
- R7: With control bit 3 (read) or bit 4 (write) set, a transaction is withheld once the window's transaction count for that direction has reached the 31-bit limit in word 3 or word 4.
- R8: With control bit 5 (read) or bit 6 (write) set, a burst is accepted only if the bytes already charged in this window plus (LEN+1) << SIZE do not exceed the 36-bit budget. The read budget is {word 6[3:0], word 5} and the write budget is {word 8[3:0], word 7}.
- R9: A limit whose enable bit is clear has no effect on its handshake.
- R10: The decision is made in the same cycle. A withheld handshake shows m_xvalid = 0 and s_xready = 0. An admitted one forwards valid and ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read-back of word reg_addr |
| s_arvalid | input | 1 | AR valid from the master |
| s_arready | output | 1 | AR ready to the master |
| s_arlen | input | 8 | AR burst length minus one |
| s_arsize | input | 3 | AR beat size exponent |
| m_arvalid | output | 1 | AR valid toward the fabric |
| m_arready | input | 1 | AR ready from the fabric |
| s_awvalid | input | 1 | AW valid from the master |
| s_awready | output | 1 | AW ready to the master |
| s_awlen | input | 8 | AW burst length minus one |
| s_awsize | input | 3 | AW beat size exponent |
| m_awvalid | output | 1 | AW valid toward the fabric |
| m_awready | input | 1 | AW ready from the fabric |
| rvalid | input | 1 | Observed R valid |
| rready | input | 1 | Observed R ready |
| rlast | input | 1 | Observed R last beat |
| bvalid | input | 1 | Observed B valid |
| bready | input | 1 | Observed B ready |

## Verification
The gating outputs are combinational from the inputs and the current counters, so they are due in the same cycle as the stimulus. The bench drives after the falling edge and compares one time step later. Counter and window effects show up in the cycle after the rising edge that records a handshake, completion or register write. The bench's model steps its own counters at that edge, so every later comparison uses state one edge old. Register read-back is due one edge after reg_addr is applied and is sampled at the next falling edge.

// File: rtl/axi_rate_gate_pkg.sv
package axi_rate_gate_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 4'd0,
    RA_OSLIM  = 4'd1,
    RA_WINLEN = 4'd2,
    RA_RDCNT  = 4'd3,
    RA_WRCNT  = 4'd4,
    RA_RDBLO  = 4'd5,
    RA_RDBHI  = 4'd6,
    RA_WRBLO  = 4'd7,
    RA_WRBHI  = 4'd8
  } reg_addr_e;

  // last member lands on bit 0
  typedef struct packed {
    logic wr_byte_en;
    logic rd_byte_en;
    logic wr_cnt_en;
    logic rd_cnt_en;
    logic wr_os_en;
    logic rd_os_en;
    logic bypass;
  } ctrl_t;

  localparam int WR_OS_LSB = 8;
endpackage

// File: rtl/arg_regs.sv
module arg_regs
  import axi_rate_gate_pkg::*;
#(
  parameter int RD_OS_W  = 7,
  parameter int WR_OS_W  = 5,
  parameter int WIN_W    = 27,
  parameter int CNT_W    = 31,
  parameter int BYTE_W   = 36,
  parameter int WIN_RST  = 1024,
  parameter int CNT_RST  = 'h4000,
  parameter int BYTE_RST = 'h4000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  output ctrl_t               cfg,
  output logic [RD_OS_W-1:0]  rd_os_lim,
  output logic [WR_OS_W-1:0]  wr_os_lim,
  output logic [WIN_W-1:0]    win_len,
  output logic [CNT_W-1:0]    rd_cnt_lim,
  output logic [CNT_W-1:0]    wr_cnt_lim,
  output logic [BYTE_W-1:0]   rd_byte_lim,
  output logic [BYTE_W-1:0]   wr_byte_lim
);
  localparam int HI_W = BYTE_W - REG_DW;
  localparam ctrl_t CTRL_RST = '{bypass: 1'b1, default: 1'b0};

  logic [REG_DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg         <= CTRL_RST;
      rd_os_lim   <= '0;
      wr_os_lim   <= '0;
      win_len     <= WIN_W'(WIN_RST);
      rd_cnt_lim  <= CNT_W'(CNT_RST);
      wr_cnt_lim  <= CNT_W'(CNT_RST);
      rd_byte_lim <= BYTE_W'(BYTE_RST);
      wr_byte_lim <= BYTE_W'(BYTE_RST);
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL:   cfg <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
        RA_OSLIM: begin
          rd_os_lim <= reg_wdata[RD_OS_W-1:0];
          wr_os_lim <= reg_wdata[WR_OS_LSB +: WR_OS_W];
        end
        RA_WINLEN: win_len    <= reg_wdata[WIN_W-1:0];
        RA_RDCNT:  rd_cnt_lim <= reg_wdata[CNT_W-1:0];
        RA_WRCNT:  wr_cnt_lim <= reg_wdata[CNT_W-1:0];
        RA_RDBLO:  rd_byte_lim[REG_DW-1:0]      <= reg_wdata;
        RA_RDBHI:  rd_byte_lim[BYTE_W-1:REG_DW] <= reg_wdata[HI_W-1:0];
        RA_WRBLO:  wr_byte_lim[REG_DW-1:0]      <= reg_wdata;
        RA_WRBHI:  wr_byte_lim[BYTE_W-1:REG_DW] <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL:   rd_mux = REG_DW'(cfg);
      RA_OSLIM: begin
        rd_mux[RD_OS_W-1:0]         = rd_os_lim;
        rd_mux[WR_OS_LSB +: WR_OS_W] = wr_os_lim;
      end
      RA_WINLEN: rd_mux = REG_DW'(win_len);
      RA_RDCNT:  rd_mux = REG_DW'(rd_cnt_lim);
      RA_WRCNT:  rd_mux = REG_DW'(wr_cnt_lim);
      RA_RDBLO:  rd_mux = rd_byte_lim[REG_DW-1:0];
      RA_RDBHI:  rd_mux = REG_DW'(rd_byte_lim[BYTE_W-1:REG_DW]);
      RA_WRBLO:  rd_mux = wr_byte_lim[REG_DW-1:0];
      RA_WRBHI:  rd_mux = REG_DW'(wr_byte_lim[BYTE_W-1:REG_DW]);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/arg_window.sv
module arg_window #(
  parameter int WIN_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  output logic             wrap
);
  logic [WIN_W-1:0] tick_cnt;

  // a zero length behaves as a one-cycle window
  always_comb wrap = (win_len == '0) || (tick_cnt >= win_len - WIN_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       tick_cnt <= '0;
    else if (wrap) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + WIN_W'(1);
  end
endmodule

// File: rtl/arg_chan.sv
module arg_chan #(
  parameter int OS_W   = 7,
  parameter int CNT_W  = 31,
  parameter int BYTE_W = 36,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              os_en,
  input  logic              cnt_en,
  input  logic              byte_en,
  input  logic [OS_W-1:0]   os_lim,
  input  logic [CNT_W-1:0]  cnt_lim,
  input  logic [BYTE_W-1:0] byte_lim,
  input  logic              win_wrap,
  input  logic              s_valid,
  input  logic              m_ready,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic              done,
  output logic              m_valid,
  output logic              s_ready,
  output logic [OS_W:0]     os_cnt,
  output logic [CNT_W-1:0]  win_cnt
);
  localparam int OSC_W   = OS_W + 1;
  localparam int BURST_W = LEN_W + (1 << SIZE_W);
  localparam int ACC_W   = BYTE_W + 8;
  localparam int SUM_W   = ACC_W + 1;

  logic [OSC_W-1:0]   os_cap;
  logic [BURST_W-1:0] burst;
  logic [ACC_W-1:0]   win_bytes;
  logic [SUM_W-1:0]   need, acc_sum;
  logic [CNT_W-1:0]   cnt_base;
  logic [ACC_W-1:0]   byte_base;
  logic               os_ok, cnt_ok, byte_ok, pass, hs;

  always_comb begin
    os_cap  = (os_lim == '0) ? (OSC_W'(1) << OS_W) : OSC_W'(os_lim);
    burst   = BURST_W'(BURST_W'(len) + BURST_W'(1)) << size;
    need    = SUM_W'(win_bytes) + SUM_W'(burst);
    os_ok   = os_cnt < os_cap;
    cnt_ok  = win_cnt < cnt_lim;
    byte_ok = need <= SUM_W'(byte_lim);
    pass    = bypass || ((!os_en || os_ok) && (!cnt_en || cnt_ok) && (!byte_en || byte_ok));
    m_valid = s_valid && pass;
    s_ready = m_ready && pass;
    hs      = s_valid && m_ready && pass;
    cnt_base  = win_wrap ? '0 : win_cnt;
    byte_base = win_wrap ? '0 : win_bytes;
    acc_sum   = SUM_W'(byte_base) + SUM_W'(burst);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      os_cnt <= '0;
    end else if (hs && !done && os_cnt != '1) begin
      os_cnt <= os_cnt + OSC_W'(1);
    end else if (done && !hs && os_cnt != '0) begin
      os_cnt <= os_cnt - OSC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt   <= '0;
      win_bytes <= '0;
    end else if (hs) begin
      win_cnt   <= (cnt_base == '1) ? cnt_base : cnt_base + CNT_W'(1);
      win_bytes <= acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
    end else begin
      win_cnt   <= cnt_base;
      win_bytes <= byte_base;
    end
  end
endmodule

// File: rtl/axi_rate_gate.sv
module axi_rate_gate
  import axi_rate_gate_pkg::*;
#(
  parameter int RD_OS_W = 7,
  parameter int WR_OS_W = 5,
  parameter int WIN_W   = 27,
  parameter int CNT_W   = 31,
  parameter int BYTE_W  = 36,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [LEN_W-1:0]  s_arlen,
  input  logic [SIZE_W-1:0] s_arsize,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic [SIZE_W-1:0] s_awsize,
  output logic              m_awvalid,
  input  logic              m_awready,
  input  logic              rvalid,
  input  logic              rready,
  input  logic              rlast,
  input  logic              bvalid,
  input  logic              bready
);
  ctrl_t               cfg;
  logic [RD_OS_W-1:0]  rd_os_lim;
  logic [WR_OS_W-1:0]  wr_os_lim;
  logic [WIN_W-1:0]    win_len;
  logic [CNT_W-1:0]    rd_cnt_lim, wr_cnt_lim;
  logic [BYTE_W-1:0]   rd_byte_lim, wr_byte_lim;
  logic                win_wrap;
  logic                rd_done, wr_done;
  logic [RD_OS_W:0]    rd_os;
  logic [WR_OS_W:0]    wr_os;
  logic [CNT_W-1:0]    rd_wc, wr_wc;

  assign rd_done = rvalid && rready && rlast;
  assign wr_done = bvalid && bready;

  arg_regs #(
    .RD_OS_W(RD_OS_W), .WR_OS_W(WR_OS_W), .WIN_W(WIN_W),
    .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg),
    .rd_os_lim(rd_os_lim), .wr_os_lim(wr_os_lim), .win_len(win_len),
    .rd_cnt_lim(rd_cnt_lim), .wr_cnt_lim(wr_cnt_lim),
    .rd_byte_lim(rd_byte_lim), .wr_byte_lim(wr_byte_lim)
  );

  arg_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .win_len(win_len), .wrap(win_wrap)
  );

  arg_chan #(
    .OS_W(RD_OS_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
  ) u_rd (
    .clk(clk), .rst(rst), .bypass(cfg.bypass), .os_en(cfg.rd_os_en),
    .cnt_en(cfg.rd_cnt_en), .byte_en(cfg.rd_byte_en), .os_lim(rd_os_lim),
    .cnt_lim(rd_cnt_lim), .byte_lim(rd_byte_lim), .win_wrap(win_wrap),
    .s_valid(s_arvalid), .m_ready(m_arready), .len(s_arlen), .size(s_arsize),
    .done(rd_done), .m_valid(m_arvalid), .s_ready(s_arready),
    .os_cnt(rd_os), .win_cnt(rd_wc)
  );

  arg_chan #(
    .OS_W(WR_OS_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
  ) u_wr (
    .clk(clk), .rst(rst), .bypass(cfg.bypass), .os_en(cfg.wr_os_en),
    .cnt_en(cfg.wr_cnt_en), .byte_en(cfg.wr_byte_en), .os_lim(wr_os_lim),
    .cnt_lim(wr_cnt_lim), .byte_lim(wr_byte_lim), .win_wrap(win_wrap),
    .s_valid(s_awvalid), .m_ready(m_awready), .len(s_awlen), .size(s_awsize),
    .done(wr_done), .m_valid(m_awvalid), .s_ready(s_awready),
    .os_cnt(wr_os), .win_cnt(wr_wc)
  );
endmodule

// File: rtl/arg_checker.sv
module arg_checker
  import axi_rate_gate_pkg::*;
#(
  parameter int RD_OS_W = 7,
  parameter int WR_OS_W = 5,
  parameter int CNT_W   = 31
) (
  input logic               clk,
  input logic               rst,
  input ctrl_t              cfg,
  input logic [RD_OS_W-1:0] rd_os_lim,
  input logic [WR_OS_W-1:0] wr_os_lim,
  input logic [RD_OS_W:0]   rd_os,
  input logic [WR_OS_W:0]   wr_os,
  input logic [CNT_W-1:0]   rd_cnt_lim,
  input logic [CNT_W-1:0]   rd_wc,
  input logic               s_arvalid, s_arready, m_arvalid, m_arready,
  input logic               s_awvalid, s_awready, m_awvalid, m_awready,
  input logic               rd_done, wr_done
);
  logic [RD_OS_W:0] rd_cap;
  logic [WR_OS_W:0] wr_cap;
  always_comb begin
    rd_cap = (rd_os_lim == '0) ? (RD_OS_W+1)'(1 << RD_OS_W) : (RD_OS_W+1)'(rd_os_lim);
    wr_cap = (wr_os_lim == '0) ? (WR_OS_W+1)'(1 << WR_OS_W) : (WR_OS_W+1)'(wr_os_lim);
  end

  p_bypass_transparent_r1: assert property (@(posedge clk) disable iff (rst)
    cfg.bypass |-> (m_arvalid == s_arvalid) && (s_arready == m_arready) &&
                   (m_awvalid == s_awvalid) && (s_awready == m_awready));

  p_rd_os_cap_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg.bypass && cfg.rd_os_en && rd_os >= rd_cap) |-> !m_arvalid && !s_arready);

  p_wr_os_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg.bypass && cfg.wr_os_en && wr_os >= wr_cap) |-> !m_awvalid && !s_awready);

  p_rd_os_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd_done && rd_os != '1) |=> rd_os == $past(rd_os) + (RD_OS_W+1)'($past(m_arvalid && m_arready)));

  p_wr_os_step_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !(m_awvalid && m_awready) && wr_os != '0) |=> wr_os == $past(wr_os) - (WR_OS_W+1)'(1));

  p_rd_count_cap_r7: assert property (@(posedge clk) disable iff (rst)
    (!cfg.bypass && cfg.rd_cnt_en && rd_wc >= rd_cnt_lim) |-> !m_arvalid);

  p_withheld_both_low_r10: assert property (@(posedge clk) disable iff (rst)
    (s_awvalid && m_awready && !m_awvalid) |-> !s_awready);
endmodule

bind axi_rate_gate arg_checker #(
  .RD_OS_W(RD_OS_W), .WR_OS_W(WR_OS_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .rd_os_lim(rd_os_lim), .wr_os_lim(wr_os_lim),
  .rd_os(rd_os), .wr_os(wr_os), .rd_cnt_lim(rd_cnt_lim), .rd_wc(rd_wc),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .s_awvalid(s_awvalid), .s_awready(s_awready), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .rd_done(rd_done), .wr_done(wr_done)
);

// File: tb/tb_axi_rate_gate.sv
module tb_axi_rate_gate;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_arvalid = 0, s_arready, m_arvalid, m_arready = 0;
  logic        s_awvalid = 0, s_awready, m_awvalid, m_awready = 0;
  logic [7:0]  s_arlen = 0, s_awlen = 0;
  logic [2:0]  s_arsize = 0, s_awsize = 0;
  logic        rvalid = 0, rready = 0, rlast = 0, bvalid = 0, bready = 0;

  int checks = 0;
  int errors = 0;

  // bench model of the programmed state
  logic [6:0] m_ctrl;
  int         m_oslim [2];
  longint     m_win, m_wcnt;
  longint     m_cnt [2];
  longint     m_byte [2];
  longint     m_os [2], m_wc [2], m_wb [2];

  always #(CYC/2) clk = ~clk;

  axi_rate_gate dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arlen(s_arlen), .s_arsize(s_arsize),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awlen(s_awlen), .s_awsize(s_awsize),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .rvalid(rvalid), .rready(rready), .rlast(rlast), .bvalid(bvalid), .bready(bready)
  );

  function automatic void model_reset();
    m_ctrl = 7'h01;
    m_oslim[0] = 0; m_oslim[1] = 0;
    m_win = 1024; m_wcnt = 0;
    for (int d = 0; d < 2; d++) begin
      m_cnt[d] = 'h4000; m_byte[d] = 'h4000;
      m_os[d] = 0; m_wc[d] = 0; m_wb[d] = 0;
    end
  endfunction

  function automatic longint burst_bytes(int len, int size);
    return longint'(len + 1) << size;
  endfunction

  function automatic bit exp_ok(int d, int len, int size);
    longint cap;
    if (m_ctrl[0]) return 1'b1;
    cap = (m_oslim[d] == 0) ? ((d == 0) ? 128 : 32) : m_oslim[d];
    if (m_ctrl[1+d] && m_os[d] >= cap) return 1'b0;
    if (m_ctrl[3+d] && m_wc[d] >= m_cnt[d]) return 1'b0;
    if (m_ctrl[5+d] && m_wb[d] + burst_bytes(len, size) > m_byte[d]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check1(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL [%s] %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: compare gating now, then step model at the rising edge
  task automatic tick(string tag, bit chk);
    bit okr, okw, hsr, hsw, dr, dw, wrap;
    #1;
    okr = exp_ok(0, int'(s_arlen), int'(s_arsize));
    okw = exp_ok(1, int'(s_awlen), int'(s_awsize));
    if (chk) begin
      check1(tag, "m_arvalid", m_arvalid, s_arvalid & okr);
      check1(tag, "s_arready", s_arready, m_arready & okr);
      check1(tag, "m_awvalid", m_awvalid, s_awvalid & okw);
      check1(tag, "s_awready", s_awready, m_awready & okw);
    end
    hsr = s_arvalid & m_arready & okr;
    hsw = s_awvalid & m_awready & okw;
    dr  = rvalid & rready & rlast;
    dw  = bvalid & bready;
    @(posedge clk);
    wrap = (m_win == 0) || (m_wcnt >= m_win - 1);
    m_wcnt = wrap ? 0 : m_wcnt + 1;
    m_os[0] = m_os[0] + hsr - dr;
    m_os[1] = m_os[1] + hsw - dw;
    m_wc[0] = (wrap ? 0 : m_wc[0]) + hsr;
    m_wc[1] = (wrap ? 0 : m_wc[1]) + hsw;
    m_wb[0] = (wrap ? 0 : m_wb[0]) + (hsr ? burst_bytes(int'(s_arlen), int'(s_arsize)) : 0);
    m_wb[1] = (wrap ? 0 : m_wb[1]) + (hsw ? burst_bytes(int'(s_awlen), int'(s_awsize)) : 0);
    if (reg_wr) begin
      case (reg_addr)
        4'd0: m_ctrl = reg_wdata[6:0];
        4'd1: begin m_oslim[0] = int'(reg_wdata[6:0]); m_oslim[1] = int'(reg_wdata[12:8]); end
        4'd2: m_win = longint'(reg_wdata[26:0]);
        4'd3: m_cnt[0] = longint'(reg_wdata[30:0]);
        4'd4: m_cnt[1] = longint'(reg_wdata[30:0]);
        4'd5: m_byte[0] = (m_byte[0] & 64'hF_0000_0000) | longint'(reg_wdata);
        4'd6: m_byte[0] = (m_byte[0] & 64'hFFFF_FFFF) | (longint'(reg_wdata[3:0]) << 32);
        4'd7: m_byte[1] = (m_byte[1] & 64'hF_0000_0000) | longint'(reg_wdata);
        4'd8: m_byte[1] = (m_byte[1] & 64'hFFFF_FFFF) | (longint'(reg_wdata[3:0]) << 32);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    s_arvalid = 0; m_arready = 0; s_awvalid = 0; m_awready = 0;
    rvalid = 0; rready = 0; rlast = 0; bvalid = 0; bready = 0;
    reg_wr = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic wreg(int a, logic [31:0] v);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = v;
    tick("R2", 1'b0);
    reg_wr = 0;
  endtask

  task automatic rd_check(int a, longint exp);
    reg_addr = 4'(a);
    tick("R2", 1'b0);
    check1("R2", $sformatf("reg word %0d", a), longint'(reg_rdata), exp);
  endtask

  initial begin
    #(CYC * 190000);
    errors++;
    $display("FAIL [R10] watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    model_reset();
    @(negedge clk);
    do_reset();

    // R2: reset values
    rd_check(0, 'h1); rd_check(1, 0); rd_check(2, 1024);
    rd_check(3, 'h4000); rd_check(4, 'h4000);
    rd_check(5, 'h4000); rd_check(6, 0); rd_check(7, 'h4000); rd_check(8, 0);

    // R1: transparent after reset even with tight limits programmed
    wreg(1, 32'h0000_0101); wreg(3, 0); wreg(4, 0);
    rd_check(1, 'h101);
    for (int i = 0; i < 60; i++) begin
      s_arvalid = 1'($urandom); m_arready = 1'($urandom);
      s_awvalid = 1'($urandom); m_awready = 1'($urandom);
      tick("R1", 1'b1);
    end

    // R4: write cap with field 0 means 32, then R5 release by B
    do_reset();
    wreg(0, 32'h4);
    s_awvalid = 1; m_awready = 1; s_awlen = 0;
    for (int i = 0; i < 40; i++) tick("R4", 1'b1);
    check1("R4", "writes in flight", m_os[1], 32);
    bvalid = 1; bready = 1;
    for (int i = 0; i < 6; i++) tick("R5", 1'b1);
    s_awvalid = 0;
    for (int i = 0; i < 4; i++) tick("R5", 1'b1);
    bvalid = 0;
    s_awvalid = 1;
    for (int i = 0; i < 8; i++) tick("R5", 1'b1);
    check1("R5", "writes in flight after release", m_os[1], 32);

    // R3: read cap with field 0 means 128
    do_reset();
    wreg(0, 32'h2);
    s_arvalid = 1; m_arready = 1;
    for (int i = 0; i < 140; i++) tick("R3", 1'b1);
    check1("R3", "reads in flight", m_os[0], 128);
    s_arvalid = 0;

    // R8 and R6: read byte budget 100 in 50-cycle windows, 16-byte bursts
    do_reset();
    wreg(2, 50); wreg(5, 100); wreg(0, 32'h20);
    s_arvalid = 1; m_arready = 1; s_arlen = 3; s_arsize = 2;
    for (int i = 0; i < 120; i++) tick("R8", 1'b1);
    s_arvalid = 0;

    // R7: write count cap 5 in 30-cycle windows
    do_reset();
    wreg(2, 30); wreg(4, 5); wreg(0, 32'h10);
    s_awvalid = 1; m_awready = 1;
    for (int i = 0; i < 70; i++) tick("R7", 1'b1);
    // R6: zero window length, one read per cycle allowed by a count limit of 1
    wreg(0, 32'h08); wreg(3, 1); wreg(2, 0);
    s_awvalid = 0; s_arvalid = 1; m_arready = 1;
    for (int i = 0; i < 12; i++) tick("R6", 1'b1);
    s_arvalid = 0;

    // R9: limits tight but every enable clear
    do_reset();
    wreg(1, 32'h0000_0101); wreg(3, 0); wreg(4, 0); wreg(5, 0); wreg(7, 0); wreg(0, 0);
    s_arvalid = 1; m_arready = 1; s_awvalid = 1; m_awready = 1;
    for (int i = 0; i < 30; i++) tick("R9", 1'b1);
    check1("R9", "reads admitted", m_wc[0] + m_os[0] > 0 ? 1 : 0, 1);

    // R10: random configurations and traffic
    for (int round = 0; round < 5; round++) begin
      do_reset();
      wreg(1, {19'd0, 5'($urandom_range(0, 6)), 1'b0, 7'($urandom_range(0, 8))});
      wreg(2, $urandom_range(0, 40));
      wreg(3, $urandom_range(0, 8)); wreg(4, $urandom_range(0, 8));
      wreg(5, $urandom_range(0, 400)); wreg(7, $urandom_range(0, 400));
      wreg(0, {25'd0, 6'($urandom), 1'(round == 4)});
      for (int i = 0; i < 600; i++) begin
        s_arvalid = 1'($urandom); m_arready = 1'($urandom);
        s_awvalid = 1'($urandom); m_awready = 1'($urandom);
        s_arlen = 8'($urandom_range(0, 15)); s_arsize = 3'($urandom_range(0, 3));
        s_awlen = 8'($urandom_range(0, 15)); s_awsize = 3'($urandom_range(0, 3));
        rvalid = (m_os[0] > 0) && 1'($urandom); rready = 1'($urandom); rlast = 1'($urandom);
        bvalid = (m_os[1] > 0) && 1'($urandom); bready = 1'($urandom);
        tick("R10", 1'b1);
      end
      idle_inputs();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule